// File: doc/BRIEF.md
# Segment Selector Descriptor Loader

This block loads one segment register in protected mode. A 16-bit selector is presented on a valid/ready request port. The block chooses either the global descriptor table, whose base and limit are static inputs, or the local descriptor table currently installed in the block. It checks that the 8-byte entry lies inside the chosen table. It then reads the entry as two 32-bit words over a simple memory read port, decodes it, checks its kind and present bit, and writes the decoded fields into a hidden descriptor cache. The address generator reads that cache.

The same request port also installs the local table. When the local-table flag accompanies a request, the selector must point into the global table at a local-table system descriptor. The base and the expanded limit of that descriptor become the table that later selectors with the table-indicator bit set will index.

Each accepted request ends with exactly one single-cycle pulse, either `done` or `fault`, and a fault code. The fault codes are: 1 for a bounds fault, 2 for a segment that is not present, and 3 for the wrong descriptor kind. Privilege comparison is left to the surrounding logic.

Top module: `seg_desc_loader`

## Requirements
- R1: Selector bits 15:3 are the index, bit 2 is the table indicator, and bits 1:0 have no effect. The entry address is the table base plus the index times 8. The low word is read from that address first, and the high word is read from the address plus 4.
- R2: A selector with bit 2 clear uses `gtab_base` and `gtab_limit`. A selector with bit 2 set uses the installed local table's base and limit.
- R3: If index*8+7 exceeds the chosen table's limit, or if bit 2 is set while no local table is installed, the load faults with code 1 and issues no memory read.
- R4: A selector with index 0 and bit 2 clear is a null selector. It completes with `done` and issues no memory read. For a segment load it clears `seg_usable`, and for a local-table load it clears `ltab_valid`. Index 0 with bit 2 set is not a null selector.
- R5: The descriptor fields are decoded from the low word `lo` and the high word `hi` as follows:
  - base = {hi[31:24], hi[7:0], lo[31:16]}
  - raw limit = {hi[19:16], lo[15:0]}
  - G = hi[23]; when G is set, the limit becomes {raw, 12'hFFF}, otherwise it is the raw limit zero-extended
  - D/B = hi[22]
  - P = hi[15]
  - privilege = hi[14:13]
  - S = hi[12]
  - type = hi[11:8]
- R6: A segment load requires S=1. A local-table load requires S=0 and type 2. If the kind is wrong, the load faults with code 3.
- R7: A descriptor of the right kind whose P bit is clear faults with code 2, the not-present fault.
- R8: Every fault leaves the segment cache and the local-table state unchanged.
- R9: After reset, `req_ready`=1 and `done`, `fault`, `mem_req_valid`, `seg_usable` and `ltab_valid` are all 0. Each accepted request produces exactly one one-cycle pulse on either `done` or `fault`. `req_ready` is high only while the block is idle.
- R10: A memory request holds `mem_req_valid` and a stable address until `mem_req_ready` is sampled high. A response word is taken in the cycle in which `mem_rsp_valid` is high.
- R11: A load that reads no memory raises `done` or `fault` on the first rising edge after the edge that accepts it. A load that reads memory raises it on the first rising edge after the edge that takes the second response word. The cache is updated on that same edge.
- R12: A successful local-table load sets `ltab_valid` and installs the base and expanded limit of the descriptor it read. Later selectors with bit 2 set index that table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gtab_base | input | 32 | Global table base address (static) |
| gtab_limit | input | GLIM_W | Global table byte limit (static) |
| req_valid | input | 1 | Load request valid |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_sel | input | 16 | Selector to load |
| req_ltab | input | 1 | 1: install local table, 0: load segment cache |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| done | output | 1 | One-cycle pulse: load completed |
| fault | output | 1 | One-cycle pulse: load faulted |
| fault_code | output | 2 | 1 bounds, 2 not present, 3 wrong kind; 0 otherwise |
| seg_usable | output | 1 | Segment cache holds a usable descriptor |
| seg_base | output | 32 | Cached segment base |
| seg_limit | output | 32 | Cached expanded segment limit |
| seg_kind | output | 4 | Cached type field |
| seg_code_data | output | 1 | Cached S bit |
| seg_dpl | output | 2 | Cached descriptor privilege level |
| seg_big | output | 1 | Cached D/B bit |
| seg_gran | output | 1 | Cached granularity bit |
| ltab_valid | output | 1 | A local table is installed |
| ltab_base | output | 32 | Installed local table base |
| ltab_limit | output | 32 | Installed local table expanded limit |

## Verification
A load that touches no memory ends on the first edge after the accepting edge. A load that fetches an entry ends on the first edge after the edge that takes the high word. The cache fields change on that same edge.

For each load, the bench records the number of the accepting edge, or the number of the edge at which its memory model's second response is taken. It then requires the end pulse to be first visible at the falling edge that immediately follows the expected edge, and to be gone one cycle later. Cache fields, read counts and read addresses are sampled at that same falling edge. A toggling ready signal stretches the fetch so that the count is anchored to the response and not to the request.

// File: rtl/seg_desc_pkg.sv
package seg_desc_pkg;

  localparam int WORD_W = 32;
  localparam int SEL_W  = 16;
  localparam int IDX_W  = SEL_W - 3;
  localparam int RAWL_W = 20;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_BOUNDS = 2'd1,
    FLT_ABSENT = 2'd2,
    FLT_KIND   = 2'd3
  } fault_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_EVAL,
    S_RD_LO,
    S_WT_LO,
    S_RD_HI,
    S_WT_HI,
    S_CHECK
  } ld_state_e;

  typedef struct packed {
    logic [WORD_W-1:0] base;
    logic [WORD_W-1:0] limit;
    logic [3:0]        kind;
    logic              code_data;
    logic [1:0]        dpl;
    logic              big;
    logic              gran;
    logic              present;
  } desc_t;

endpackage

// File: rtl/seg_sel_addr.sv
module seg_sel_addr
  import seg_desc_pkg::*;
#(
  parameter int GLIM_W = 16
) (
  input  logic [SEL_W-1:2]  sel_hi,
  input  logic [WORD_W-1:0] gbase,
  input  logic [GLIM_W-1:0] glimit,
  input  logic [WORD_W-1:0] lbase,
  input  logic [WORD_W-1:0] llimit,
  input  logic              lvalid,
  output logic              uses_local,
  output logic              is_null,
  output logic              out_of_bounds,
  output logic [WORD_W-1:0] entry_addr
);

  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] offs;
  logic [WORD_W-1:0] last_byte;
  logic [WORD_W-1:0] tlimit;
  logic [WORD_W-1:0] tbase;

  always_comb begin
    idx           = sel_hi[SEL_W-1:3];
    uses_local    = sel_hi[2];
    offs          = WORD_W'({idx, 3'b000});
    last_byte     = WORD_W'({idx, 3'b111});
    tlimit        = uses_local ? llimit : WORD_W'(glimit);
    tbase         = uses_local ? lbase  : gbase;
    is_null       = (idx == '0) && !uses_local;
    out_of_bounds = (uses_local && !lvalid) || (last_byte > tlimit);
    entry_addr    = tbase + offs;
  end

endmodule

// File: rtl/seg_desc_decode.sv
module seg_desc_decode
  import seg_desc_pkg::*;
(
  input  logic [WORD_W-1:0] lo,
  input  logic [WORD_W-1:0] hi,
  output desc_t             dec
);

  logic [RAWL_W-1:0] raw_lim;
  logic              unused_hi_bits;

  // High word: base[31:24] | G | D/B | two spare bits | limit[19:16]
  //            | P | DPL | S | type | base[23:16]
  always_comb begin
    raw_lim       = {hi[19:16], lo[15:0]};
    dec.base      = {hi[31:24], hi[7:0], lo[31:16]};
    dec.gran      = hi[23];
    dec.big       = hi[22];
    dec.present   = hi[15];
    dec.dpl       = hi[14:13];
    dec.code_data = hi[12];
    dec.kind      = hi[11:8];
    dec.limit     = dec.gran ? {raw_lim, 12'hFFF} : WORD_W'(raw_lim);
  end

  assign unused_hi_bits = ^hi[21:20];

endmodule

// File: rtl/seg_load_ctrl.sv
module seg_load_ctrl
  import seg_desc_pkg::*;
#(
  parameter logic [3:0] LTAB_KIND = 4'h2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SEL_W-1:2]  req_sel_hi,
  input  logic              req_ltab,
  output logic [SEL_W-1:2]  sel_q,
  input  logic              uses_local,
  input  logic              is_null,
  input  logic              out_of_bounds,
  input  logic [WORD_W-1:0] entry_addr,
  input  logic              dec_present,
  input  logic              dec_code_data,
  input  logic [3:0]        dec_kind,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [WORD_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data,
  output logic [WORD_W-1:0] lo_q,
  output logic [WORD_W-1:0] hi_q,
  output logic              commit_seg,
  output logic              commit_ltab,
  output logic              clear_seg,
  output logic              clear_ltab,
  output logic              done,
  output logic              fault,
  output fault_e            fault_code
);

  ld_state_e         st;
  logic              ltab_q;
  logic [WORD_W-1:0] addr_q;
  logic              ev_fetch;
  fault_e            ev_code;
  logic              kind_ok;
  fault_e            ck_code;

  always_comb begin
    if (ltab_q && uses_local) begin
      ev_code  = FLT_BOUNDS;
      ev_fetch = 1'b0;
    end else if (is_null) begin
      ev_code  = FLT_NONE;
      ev_fetch = 1'b0;
    end else if (out_of_bounds) begin
      ev_code  = FLT_BOUNDS;
      ev_fetch = 1'b0;
    end else begin
      ev_code  = FLT_NONE;
      ev_fetch = 1'b1;
    end

    kind_ok = ltab_q ? (!dec_code_data && (dec_kind == LTAB_KIND)) : dec_code_data;
    if (!kind_ok)          ck_code = FLT_KIND;
    else if (!dec_present) ck_code = FLT_ABSENT;
    else                   ck_code = FLT_NONE;

    req_ready     = (st == S_IDLE);
    mem_req_valid = (st == S_RD_LO) || (st == S_RD_HI);
    mem_req_addr  = addr_q;
    clear_seg     = (st == S_EVAL) && !ev_fetch && (ev_code == FLT_NONE) && !ltab_q;
    clear_ltab    = (st == S_EVAL) && !ev_fetch && (ev_code == FLT_NONE) && ltab_q;
    commit_seg    = (st == S_CHECK) && (ck_code == FLT_NONE) && !ltab_q;
    commit_ltab   = (st == S_CHECK) && (ck_code == FLT_NONE) && ltab_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      sel_q      <= '0;
      ltab_q     <= 1'b0;
      addr_q     <= '0;
      lo_q       <= '0;
      hi_q       <= '0;
      done       <= 1'b0;
      fault      <= 1'b0;
      fault_code <= FLT_NONE;
    end else begin
      done       <= 1'b0;
      fault      <= 1'b0;
      fault_code <= FLT_NONE;
      unique case (st)
        S_IDLE: begin
          if (req_valid) begin
            sel_q  <= req_sel_hi;
            ltab_q <= req_ltab;
            st     <= S_EVAL;
          end
        end
        S_EVAL: begin
          if (ev_fetch) begin
            addr_q <= entry_addr;
            st     <= S_RD_LO;
          end else begin
            st <= S_IDLE;
            if (ev_code != FLT_NONE) begin
              fault      <= 1'b1;
              fault_code <= ev_code;
            end else begin
              done <= 1'b1;
            end
          end
        end
        S_RD_LO: if (mem_req_ready) st <= S_WT_LO;
        S_WT_LO: begin
          if (mem_rsp_valid) begin
            lo_q   <= mem_rsp_data;
            addr_q <= addr_q + WORD_W'(4);
            st     <= S_RD_HI;
          end
        end
        S_RD_HI: if (mem_req_ready) st <= S_WT_HI;
        S_WT_HI: begin
          if (mem_rsp_valid) begin
            hi_q <= mem_rsp_data;
            st   <= S_CHECK;
          end
        end
        S_CHECK: begin
          st <= S_IDLE;
          if (ck_code != FLT_NONE) begin
            fault      <= 1'b1;
            fault_code <= ck_code;
          end else begin
            done <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/seg_desc_loader.sv
module seg_desc_loader
  import seg_desc_pkg::*;
#(
  parameter int         GLIM_W    = 16,
  parameter logic [3:0] LTAB_KIND = 4'h2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       gtab_base,
  input  logic [GLIM_W-1:0] gtab_limit,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [15:0]       req_sel,
  input  logic              req_ltab,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [31:0]       mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  output logic              done,
  output logic              fault,
  output logic [1:0]        fault_code,
  output logic              seg_usable,
  output logic [31:0]       seg_base,
  output logic [31:0]       seg_limit,
  output logic [3:0]        seg_kind,
  output logic              seg_code_data,
  output logic [1:0]        seg_dpl,
  output logic              seg_big,
  output logic              seg_gran,
  output logic              ltab_valid,
  output logic [31:0]       ltab_base,
  output logic [31:0]       ltab_limit
);

  logic [SEL_W-1:2]  sel_q;
  logic              uses_local;
  logic              is_null;
  logic              out_of_bounds;
  logic [WORD_W-1:0] entry_addr;
  logic [WORD_W-1:0] lo_q;
  logic [WORD_W-1:0] hi_q;
  desc_t             dec;
  logic              commit_seg;
  logic              commit_ltab;
  logic              clear_seg;
  logic              clear_ltab;
  fault_e            fcode;
  logic              unused_rpl;

  assign unused_rpl = ^req_sel[1:0];

  seg_sel_addr #(.GLIM_W(GLIM_W)) u_addr (
    .sel_hi        (sel_q),
    .gbase         (gtab_base),
    .glimit        (gtab_limit),
    .lbase         (ltab_base),
    .llimit        (ltab_limit),
    .lvalid        (ltab_valid),
    .uses_local    (uses_local),
    .is_null       (is_null),
    .out_of_bounds (out_of_bounds),
    .entry_addr    (entry_addr)
  );

  seg_desc_decode u_dec (
    .lo  (lo_q),
    .hi  (hi_q),
    .dec (dec)
  );

  seg_load_ctrl #(.LTAB_KIND(LTAB_KIND)) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_sel_hi    (req_sel[SEL_W-1:2]),
    .req_ltab      (req_ltab),
    .sel_q         (sel_q),
    .uses_local    (uses_local),
    .is_null       (is_null),
    .out_of_bounds (out_of_bounds),
    .entry_addr    (entry_addr),
    .dec_present   (dec.present),
    .dec_code_data (dec.code_data),
    .dec_kind      (dec.kind),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .lo_q          (lo_q),
    .hi_q          (hi_q),
    .commit_seg    (commit_seg),
    .commit_ltab   (commit_ltab),
    .clear_seg     (clear_seg),
    .clear_ltab    (clear_ltab),
    .done          (done),
    .fault         (fault),
    .fault_code    (fcode)
  );

  assign fault_code = fcode;

  // Hidden segment cache.
  always_ff @(posedge clk) begin
    if (rst) begin
      seg_usable    <= 1'b0;
      seg_base      <= '0;
      seg_limit     <= '0;
      seg_kind      <= '0;
      seg_code_data <= 1'b0;
      seg_dpl       <= '0;
      seg_big       <= 1'b0;
      seg_gran      <= 1'b0;
    end else if (commit_seg) begin
      seg_usable    <= 1'b1;
      seg_base      <= dec.base;
      seg_limit     <= dec.limit;
      seg_kind      <= dec.kind;
      seg_code_data <= dec.code_data;
      seg_dpl       <= dec.dpl;
      seg_big       <= dec.big;
      seg_gran      <= dec.gran;
    end else if (clear_seg) begin
      seg_usable <= 1'b0;
    end
  end

  // Installed local table.
  always_ff @(posedge clk) begin
    if (rst) begin
      ltab_valid <= 1'b0;
      ltab_base  <= '0;
      ltab_limit <= '0;
    end else if (commit_ltab) begin
      ltab_valid <= 1'b1;
      ltab_base  <= dec.base;
      ltab_limit <= dec.limit;
    end else if (clear_ltab) begin
      ltab_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/seg_desc_loader_chk.sv
module seg_desc_loader_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_ready,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_addr,
  input logic        done,
  input logic        fault,
  input logic [1:0]  fault_code,
  input logic        seg_usable,
  input logic [31:0] seg_base,
  input logic        ltab_valid,
  input logic [31:0] ltab_base
);

  p_single_end_r9: assert property (@(posedge clk) disable iff (rst)
    !(done && fault));

  p_pulse_once_r9: assert property (@(posedge clk) disable iff (rst)
    (done || fault) |=> !(done || fault));

  p_busy_no_accept_r9: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !req_ready);

  p_hold_req_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  p_cache_kept_r8: assert property (@(posedge clk) disable iff (rst)
    fault |-> ($stable(seg_base) && $stable(seg_usable) &&
               $stable(ltab_base) && $stable(ltab_valid)));

  p_code_given_r7: assert property (@(posedge clk) disable iff (rst)
    fault |-> (fault_code != 2'd0));

endmodule

bind seg_desc_loader seg_desc_loader_chk chk_i (
  .clk           (clk),
  .rst           (rst),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .done          (done),
  .fault         (fault),
  .fault_code    (fault_code),
  .seg_usable    (seg_usable),
  .seg_base      (seg_base),
  .ltab_valid    (ltab_valid),
  .ltab_base     (ltab_base)
);

// File: tb/seg_desc_loader_tb_top.sv
`timescale 1ns/1ps
module seg_desc_loader_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] gtab_base = 32'h0000_0100;
  logic [15:0] gtab_limit = 16'h003F;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_sel = 16'h0;
  logic        req_ltab = 1'b0;
  logic        mem_req_valid;
  logic        mem_ready = 1'b1;
  logic [31:0] mem_req_addr;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_data = 32'h0;
  logic        done, fault;
  logic [1:0]  fault_code;
  logic        seg_usable, seg_code_data, seg_big, seg_gran;
  logic [31:0] seg_base, seg_limit;
  logic [3:0]  seg_kind;
  logic [1:0]  seg_dpl;
  logic        ltab_valid;
  logic [31:0] ltab_base, ltab_limit;

  logic [31:0] mem [0:255];
  int          cyc = 0;
  int          nreads = 0;
  int          last_rsp_edge = 0;
  logic [31:0] prev_addr = 32'h0;
  logic [31:0] last_addr = 32'h0;
  logic        stall_en = 1'b0;

  int n_chk = 0;
  int n_err = 0;
  logic       got_fault;
  logic [1:0] got_code;
  bit         finished = 1'b0;

  always #10 clk = ~clk;

  seg_desc_loader dut_i (
    .clk(clk), .rst(rst), .gtab_base(gtab_base), .gtab_limit(gtab_limit),
    .req_valid(req_valid), .req_ready(req_ready), .req_sel(req_sel), .req_ltab(req_ltab),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(rsp_valid), .mem_rsp_data(rsp_data),
    .done(done), .fault(fault), .fault_code(fault_code),
    .seg_usable(seg_usable), .seg_base(seg_base), .seg_limit(seg_limit), .seg_kind(seg_kind),
    .seg_code_data(seg_code_data), .seg_dpl(seg_dpl), .seg_big(seg_big), .seg_gran(seg_gran),
    .ltab_valid(ltab_valid), .ltab_base(ltab_base), .ltab_limit(ltab_limit)
  );

  // Memory model: answers one cycle after a request is accepted.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rsp_valid) last_rsp_edge <= cyc + 1;
    mem_ready <= stall_en ? ~mem_ready : 1'b1;
    rsp_valid <= 1'b0;
    if (mem_req_valid && mem_ready) begin
      rsp_valid <= 1'b1;
      rsp_data  <= mem[mem_req_addr[9:2]];
      nreads    <= nreads + 1;
      prev_addr <= last_addr;
      last_addr <= mem_req_addr;
    end
  end

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_lo(input logic [31:0] b, input logic [19:0] l);
    return {b[15:0], l[15:0]};
  endfunction

  function automatic logic [31:0] mk_hi(input logic [31:0] b, input logic [19:0] l,
                                        input logic g, input logic db, input logic [1:0] dpl,
                                        input logic s, input logic [3:0] typ, input logic p);
    return {b[31:24], g, db, 2'b00, l[19:16], p, dpl, s, typ, b[23:16]};
  endfunction

  task automatic put(input logic [31:0] at, input logic [31:0] b, input logic [19:0] l,
                     input logic g, input logic db, input logic [1:0] dpl,
                     input logic s, input logic [3:0] typ, input logic p);
    mem[at[9:2]]       = mk_lo(b, l);
    mem[at[9:2] + 8'd1] = mk_hi(b, l, g, db, dpl, s, typ, p);
  endtask

  // One load; checks end timing (R11), read count and single pulse (R9).
  task automatic do_load(input logic [15:0] sel, input logic lt, input int exp_reads,
                         input string rq);
    int k0;
    int r0;
    int waited;
    @(negedge clk);
    chk("R9", {rq, " ready before request"}, {31'h0, req_ready}, 32'h1);
    req_sel = sel; req_ltab = lt; req_valid = 1'b1;
    k0 = cyc; r0 = nreads;
    @(negedge clk);
    req_valid = 1'b0;
    waited = 0;
    while (!(done || fault) && waited < 200) begin
      @(negedge clk);
      waited++;
    end
    if (waited >= 200) begin
      chk("R9", {rq, " end pulse missing"}, 32'h0, 32'h1);
    end else begin
      if (exp_reads == 0)
        chk("R11", {rq, " end edge (no read)"}, cyc, k0 + 2);
      else
        chk("R11", {rq, " end edge (after high word)"}, cyc, last_rsp_edge + 1);
    end
    got_fault = fault;
    got_code  = fault_code;
    chk(exp_reads == 0 ? "R3" : "R1", {rq, " memory reads"}, nreads - r0, exp_reads);
    @(negedge clk);
    chk("R9", {rq, " pulse lasts one cycle"}, {30'h0, done, fault}, 32'h0);
  endtask

  task automatic t_reset;
    chk("R9", "reset ready", {31'h0, req_ready}, 32'h1);
    chk("R9", "reset done/fault/memreq", {29'h0, done, fault, mem_req_valid}, 32'h0);
    chk("R9", "reset usable flags", {30'h0, seg_usable, ltab_valid}, 32'h0);
  endtask

  task automatic t_global_code;
    do_load(16'h000B, 1'b0, 2, "global code");
    chk("R1", "low word address", prev_addr, 32'h0000_0108);
    chk("R1", "high word address", last_addr, 32'h0000_010C);
    chk("R5", "done no fault", {31'h0, got_fault}, 32'h0);
    chk("R5", "base", seg_base, 32'h1234_5678);
    chk("R5", "limit byte gran", seg_limit, 32'h0000_ABCD);
    chk("R5", "kind/s/dpl/big/gran",
        {23'h0, seg_kind, seg_code_data, seg_dpl, seg_big, seg_gran},
        {23'h0, 4'hA, 1'b1, 2'd3, 1'b1, 1'b0});
    chk("R2", "usable", {31'h0, seg_usable}, 32'h1);
  endtask

  task automatic t_gran;
    do_load(16'h0010, 1'b0, 2, "global data gran");
    chk("R5", "base", seg_base, 32'h00C0_FFEE);
    chk("R5", "limit page gran", seg_limit, 32'h0000_3FFF);
    chk("R5", "gran bit", {31'h0, seg_gran}, 32'h1);
  endtask

  task automatic t_not_present;
    do_load(16'h0018, 1'b0, 2, "not present");
    chk("R7", "fault code", {29'h0, got_fault, got_code}, {29'h0, 1'b1, 2'd2});
    chk("R8", "base kept", seg_base, 32'h00C0_FFEE);
    chk("R8", "limit kept", seg_limit, 32'h0000_3FFF);
  endtask

  task automatic t_kind_seg;
    do_load(16'h0020, 1'b0, 2, "system as segment");
    chk("R6", "fault code", {29'h0, got_fault, got_code}, {29'h0, 1'b1, 2'd3});
    chk("R8", "usable kept", {31'h0, seg_usable}, 32'h1);
  endtask

  task automatic t_bounds_global;
    do_load(16'h0040, 1'b0, 0, "global past limit");
    chk("R3", "fault code", {29'h0, got_fault, got_code}, {29'h0, 1'b1, 2'd1});
    do_load(16'h0038, 1'b0, 2, "global last entry in bounds");
    chk("R3", "last entry reads", last_addr, 32'h0000_013C);
  endtask

  task automatic t_local_before;
    do_load(16'h0004, 1'b0, 0, "local without table");
    chk("R3", "fault code", {29'h0, got_fault, got_code}, {29'h0, 1'b1, 2'd1});
  endtask

  task automatic t_ltab_faults;
    do_load(16'h0028, 1'b1, 2, "ltab wrong type");
    chk("R6", "fault code type", {29'h0, got_fault, got_code}, {29'h0, 1'b1, 2'd3});
    do_load(16'h0008, 1'b1, 2, "ltab from code seg");
    chk("R6", "fault code s", {29'h0, got_fault, got_code}, {29'h0, 1'b1, 2'd3});
    do_load(16'h0030, 1'b1, 2, "ltab absent");
    chk("R7", "fault code", {29'h0, got_fault, got_code}, {29'h0, 1'b1, 2'd2});
    do_load(16'h0024, 1'b1, 0, "ltab via local");
    chk("R3", "fault code", {29'h0, got_fault, got_code}, {29'h0, 1'b1, 2'd1});
    chk("R8", "ltab still invalid", {31'h0, ltab_valid}, 32'h0);
  endtask

  task automatic t_ltab_ok;
    do_load(16'h0023, 1'b1, 2, "ltab install");
    chk("R12", "no fault", {31'h0, got_fault}, 32'h0);
    chk("R12", "ltab valid", {31'h0, ltab_valid}, 32'h1);
    chk("R12", "ltab base", ltab_base, 32'h0000_0200);
    chk("R12", "ltab limit", ltab_limit, 32'h0000_0017);
  endtask

  task automatic t_local_seg;
    do_load(16'h0004, 1'b0, 2, "local idx0");
    chk("R4", "local idx0 not null", {31'h0, seg_usable}, 32'h1);
    chk("R2", "local low addr", prev_addr, 32'h0000_0200);
    chk("R2", "local base", seg_base, 32'h4000_0000);
    stall_en = 1'b1;
    do_load(16'h000E, 1'b0, 2, "local idx1 stalled");
    stall_en = 1'b0;
    chk("R10", "stalled high addr", last_addr, 32'h0000_020C);
    chk("R10", "stalled base", seg_base, 32'h5000_1000);
    chk("R5", "full limit", seg_limit, 32'hFFFF_FFFF);
    do_load(16'h001C, 1'b0, 0, "local past limit");
    chk("R3", "fault code", {29'h0, got_fault, got_code}, {29'h0, 1'b1, 2'd1});
  endtask

  task automatic t_null;
    do_load(16'h0000, 1'b0, 0, "null");
    chk("R4", "done", {31'h0, got_fault}, 32'h0);
    chk("R4", "unusable", {31'h0, seg_usable}, 32'h0);
    do_load(16'h000B, 1'b0, 2, "reload");
    do_load(16'h0003, 1'b0, 0, "null with rpl");
    chk("R1", "rpl ignored null", {31'h0, seg_usable}, 32'h0);
  endtask

  task automatic t_ltab_null;
    do_load(16'h0000, 1'b1, 0, "ltab null");
    chk("R4", "ltab cleared", {31'h0, ltab_valid}, 32'h0);
    do_load(16'h0004, 1'b0, 0, "local after clear");
    chk("R3", "fault code", {29'h0, got_fault, got_code}, {29'h0, 1'b1, 2'd1});
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    // global table at 0x100
    put(32'h108, 32'h1234_5678, 20'h0ABCD, 1'b0, 1'b1, 2'd3, 1'b1, 4'hA, 1'b1);
    put(32'h110, 32'h00C0_FFEE, 20'h00003, 1'b1, 1'b0, 2'd0, 1'b1, 4'h2, 1'b1);
    put(32'h118, 32'h0BAD_0000, 20'h00010, 1'b0, 1'b0, 2'd0, 1'b1, 4'h2, 1'b0);
    put(32'h120, 32'h0000_0200, 20'h00017, 1'b0, 1'b0, 2'd0, 1'b0, 4'h2, 1'b1);
    put(32'h128, 32'h0000_0300, 20'h00017, 1'b0, 1'b0, 2'd0, 1'b0, 4'h9, 1'b1);
    put(32'h130, 32'h0000_0300, 20'h00017, 1'b0, 1'b0, 2'd0, 1'b0, 4'h2, 1'b0);
    put(32'h138, 32'h7700_0000, 20'h00100, 1'b0, 1'b0, 2'd1, 1'b1, 4'h3, 1'b1);
    // local table at 0x200
    put(32'h200, 32'h4000_0000, 20'h00010, 1'b0, 1'b0, 2'd3, 1'b1, 4'h3, 1'b1);
    put(32'h208, 32'h5000_1000, 20'hFFFFF, 1'b1, 1'b1, 2'd3, 1'b1, 4'h3, 1'b1);
    put(32'h210, 32'h6000_0000, 20'h00010, 1'b0, 1'b0, 2'd0, 1'b0, 4'h2, 1'b1);

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_global_code();
    t_gran();
    t_not_present();
    t_kind_seg();
    t_bounds_global();
    t_local_before();
    t_ltab_faults();
    t_ltab_ok();
    t_local_seg();
    t_null();
    t_ltab_null();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

endmodule